// File: doc/BRIEF.md
# Port status frame writer

This block produces the status frames that one storage-controller port stores in its 256-byte received-frame area when a command finishes or the port comes out of reset. A completion request carries a slot number, a 16-bit task-file word (error byte in the upper half, status byte in the lower half) and a frame kind. The block streams the frame out one byte at a time over a valid/ready write port: either a 20-byte register frame or an 8-byte set-bits frame that carries a one-hot slot mask. It then updates the port's interrupt-status flags and its command-issue and active bitmaps, and drives the controller interrupt.

The request side is valid/ready. While a frame is being written and its bookkeeping applied, `req_ready` is low. The write port holds its address and data steady whenever `fis_ready` is low, so the memory behind it may stall for any number of cycles. The register and bitmap inputs (`fis_en`, `pkt_dev`, `glb_ie`, the set and clear vectors) are plain levels and pulses.

Top module: `statfis_top`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the updates of R6 to R8 have been applied.
- R2: Frame bytes leave on `fis_addr`/`fis_data` whenever `fis_valid` is high. A byte moves on each edge where `fis_ready` is also high. While `fis_ready` is low, the offered byte and its address do not change. Addresses rise by one for each byte.
- R3: Kinds 0 and 3 (register completion) write 20 bytes at addresses 0x40 to 0x53. Byte 0 is 0x34, byte 1 is 0x40, byte 2 is the status byte (task-file bits 7:0), byte 3 is the error byte (bits 15:8), and every other byte is 0x00.
- R4: Kind 1 (queued completion) writes 8 bytes at 0x58 to 0x5F: 0xA1, 0x40, status, error, then the 32-bit mask (1 << slot) with its least significant byte first.
- R5: Kind 2 (reset frame) writes the register frame of R3 with a signature placed in it. Bytes 4 and 12 are 0x01. Bytes 5 and 6 are 0x00 and 0x00 when `pkt_dev` is 0, and 0x14 and 0xEB when it is 1.
- R6: `fis_en` is sampled when the request is taken. When it is 0, no byte is written and no frame-received flag is set, but the error flag and bitmap updates still apply. The updates then appear one cycle after acceptance.
- R7: In `port_is`, bit 0 is set when a register or reset frame has been written, and bit 1 when a set-bits frame has been written. Bit 2 is set for any kind whose status byte has bit 0 set. Writing a one to a bit through `port_is_clr` clears it, and a same-cycle set wins over the clear.
- R8: Kinds 0 and 3 clear `cmd_issue[slot]`. Kind 1 clears `active[slot]` and leaves `cmd_issue` alone. Kind 2 changes neither. The updates appear on the edge after the last byte is accepted.
- R9: Each bit of `ci_set` and `act_set` sets the matching bit of `cmd_issue` or `active` on the next edge, and wins over a same-cycle completion clear.
- R10: `hba_is` has bit PORT_IDX equal to the OR of `port_is` and all other bits 0. `irq` is high exactly when `hba_is` is nonzero and `glb_ie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Completion request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 2 | 0/3 register, 1 queued, 2 reset frame |
| req_slot | input | SLOT_W (5) | Completed command slot |
| req_tfd | input | 16 | Task-file word: error in 15:8, status in 7:0 |
| fis_en | input | 1 | Frame receive enable |
| pkt_dev | input | 1 | Attached device is a packet device |
| glb_ie | input | 1 | Global interrupt enable |
| port_is_clr | input | 3 | Write-one-to-clear strobes for `port_is` |
| ci_set | input | SLOTS (32) | Command-issue set strobes |
| act_set | input | SLOTS (32) | Active-bitmap set strobes |
| fis_valid | output | 1 | Frame byte offered |
| fis_ready | input | 1 | Frame memory accepts the byte |
| fis_addr | output | 8 | Byte address in the received-frame area |
| fis_data | output | 8 | Byte value |
| port_is | output | 3 | Port interrupt-status flags |
| cmd_issue | output | SLOTS (32) | Command-issue bitmap |
| active | output | SLOTS (32) | Queued-command active bitmap |
| hba_is | output | NPORTS (4) | Controller-level per-port summary |
| irq | output | 1 | Controller interrupt request |

## Verification
Several properties are checked on every cycle: the offered byte is held under back-pressure, only the two frame windows are addressed, and requests are refused while a frame is in flight. Also checked every cycle are the write-one-to-clear behaviour, the priority of set strobes, the retirement of the completed slot in the right bitmap, and the gating of the interrupt by the enable. The byte contents of each frame kind, the reset signatures, the slot mask at slots 0 and 31 and the suppressed write with receive disabled are shown only by the bench scenarios. So are the exact flag combinations after error and non-error completions, which the scoreboard compares byte by byte under an irregular ready pattern.

// File: rtl/statfis_pkg.sv
package statfis_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_QUEUED = 2'd1,
    KIND_RESET  = 2'd2,
    KIND_REG_B  = 2'd3
  } fis_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_FIN  = 2'd2
  } tx_state_e;

  localparam logic [7:0] TYPE_REG  = 8'h34;
  localparam logic [7:0] TYPE_BITS = 8'hA1;
  localparam logic [7:0] IRQ_FLAG  = 8'h40;
  localparam logic [7:0] BASE_REG  = 8'h40;
  localparam logic [7:0] BASE_BITS = 8'h58;
  localparam int         LEN_REG   = 20;
  localparam int         LEN_BITS  = 8;
  localparam int         IDX_W     = 5;

  localparam int IS_W   = 3;
  localparam int IS_REG = 0;
  localparam int IS_SDB = 1;
  localparam int IS_TFE = 2;

  localparam logic [31:0] SIG_DISK = 32'h0000_0101;
  localparam logic [31:0] SIG_PKT  = 32'hEB14_0101;
endpackage

// File: rtl/statfis_frame_gen.sv
module statfis_frame_gen
  import statfis_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  fis_kind_e         kind_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [15:0]       tfd_i,
  input  logic              pkt_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [IDX_W-1:0]  last_idx_o,
  output logic [7:0]        addr_o,
  output logic [7:0]        data_o
);
  logic        bits_frame;
  logic        rst_frame;
  logic [31:0] mask;
  logic [31:0] sig;
  logic [7:0]  stat_b;
  logic [7:0]  err_b;

  assign bits_frame = (kind_i == KIND_QUEUED);
  assign rst_frame  = (kind_i == KIND_RESET);
  assign mask       = 32'd1 << slot_i;
  assign sig        = pkt_i ? SIG_PKT : SIG_DISK;
  assign stat_b     = tfd_i[7:0];
  assign err_b      = tfd_i[15:8];

  assign last_idx_o = bits_frame ? IDX_W'(LEN_BITS - 1) : IDX_W'(LEN_REG - 1);
  assign addr_o     = (bits_frame ? BASE_BITS : BASE_REG) + {{(8-IDX_W){1'b0}}, idx_i};

  always_comb begin
    data_o = 8'h00;
    if (bits_frame) begin
      case (idx_i)
        5'd0: data_o = TYPE_BITS;
        5'd1: data_o = IRQ_FLAG;
        5'd2: data_o = stat_b;
        5'd3: data_o = err_b;
        5'd4: data_o = mask[7:0];
        5'd5: data_o = mask[15:8];
        5'd6: data_o = mask[23:16];
        5'd7: data_o = mask[31:24];
        default: data_o = 8'h00;
      endcase
    end else begin
      case (idx_i)
        5'd0:  data_o = TYPE_REG;
        5'd1:  data_o = IRQ_FLAG;
        5'd2:  data_o = stat_b;
        5'd3:  data_o = err_b;
        5'd4:  data_o = rst_frame ? sig[15:8]  : 8'h00;
        5'd5:  data_o = rst_frame ? sig[23:16] : 8'h00;
        5'd6:  data_o = rst_frame ? sig[31:24] : 8'h00;
        5'd12: data_o = rst_frame ? sig[7:0]   : 8'h00;
        default: data_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/statfis_byte_tx.sv
module statfis_byte_tx
  import statfis_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  fis_kind_e         req_kind_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic [15:0]       req_tfd_i,
  input  logic              fis_en_i,
  input  logic              pkt_i,
  input  logic              out_ready_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  output logic              out_valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output fis_kind_e         kind_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [15:0]       tfd_o,
  output logic              pkt_o,
  output logic              wrote_o,
  output logic              fin_o
);
  tx_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx_o   <= '0;
      kind_o  <= KIND_REG;
      slot_o  <= '0;
      tfd_o   <= '0;
      pkt_o   <= 1'b0;
      wrote_o <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid_i) begin
          kind_o  <= req_kind_i;
          slot_o  <= req_slot_i;
          tfd_o   <= req_tfd_i;
          pkt_o   <= pkt_i;
          wrote_o <= fis_en_i;
          idx_o   <= '0;
          st      <= fis_en_i ? ST_SEND : ST_FIN;
        end
        ST_SEND: if (out_ready_i) begin
          if (idx_o == last_idx_i) st <= ST_FIN;
          else                     idx_o <= idx_o + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st == ST_IDLE);
  assign out_valid_o = (st == ST_SEND);
  assign fin_o       = (st == ST_FIN);
endmodule

// File: rtl/statfis_status.sv
module statfis_status
  import statfis_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int NPORTS   = 4,
  parameter int PORT_IDX = 1,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_i,
  input  fis_kind_e         kind_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              err_bit_i,
  input  logic              wrote_i,
  input  logic [IS_W-1:0]   is_clr_i,
  input  logic [SLOTS-1:0]  ci_set_i,
  input  logic [SLOTS-1:0]  act_set_i,
  input  logic              glb_ie_i,
  output logic [IS_W-1:0]   port_is_o,
  output logic [SLOTS-1:0]  ci_o,
  output logic [SLOTS-1:0]  act_o,
  output logic [NPORTS-1:0] hba_is_o,
  output logic              irq_o
);
  logic [IS_W-1:0]  set_v;
  logic [SLOTS-1:0] onehot;
  logic [SLOTS-1:0] ci_clr;
  logic [SLOTS-1:0] act_clr;
  logic             is_queued;
  logic             retires_ci;

  assign is_queued  = (kind_i == KIND_QUEUED);
  assign retires_ci = (kind_i == KIND_REG) || (kind_i == KIND_REG_B);
  assign onehot     = SLOTS'(1) << slot_i;

  always_comb begin
    set_v         = '0;
    set_v[IS_REG] = fin_i && wrote_i && !is_queued;
    set_v[IS_SDB] = fin_i && wrote_i && is_queued;
    set_v[IS_TFE] = fin_i && err_bit_i;
  end

  assign ci_clr  = (fin_i && retires_ci) ? onehot : '0;
  assign act_clr = (fin_i && is_queued)  ? onehot : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_is_o <= '0;
      ci_o      <= '0;
      act_o     <= '0;
    end else begin
      port_is_o <= set_v | (port_is_o & ~is_clr_i);
      ci_o      <= (ci_o & ~ci_clr) | ci_set_i;
      act_o     <= (act_o & ~act_clr) | act_set_i;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_hba
    if (p == PORT_IDX) begin : g_own
      assign hba_is_o[p] = |port_is_o;
    end else begin : g_other
      assign hba_is_o[p] = 1'b0;
    end
  end

  assign irq_o = glb_ie_i && (|hba_is_o);

  for (genvar k = 0; k < IS_W; k++) begin : g_w1c_chk
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_clr_i[k] && !set_v[k] |=> !port_is_o[k]);
  end

  assert_ci_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i && retires_ci && !ci_set_i[slot_i] |=> !ci_o[$past(slot_i)]);

  assert_act_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i && is_queued && !act_set_i[slot_i] |=> !act_o[$past(slot_i)]);

  assert_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ci_o & $past(ci_set_i)) == $past(ci_set_i)) &&
             ((act_o & $past(act_set_i)) == $past(act_set_i)));
endmodule

// File: rtl/statfis_top.sv
module statfis_top
  import statfis_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int NPORTS   = 4,
  parameter int PORT_IDX = 1,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [15:0]       req_tfd,
  input  logic              fis_en,
  input  logic              pkt_dev,
  input  logic              glb_ie,
  input  logic [2:0]        port_is_clr,
  input  logic [SLOTS-1:0]  ci_set,
  input  logic [SLOTS-1:0]  act_set,
  output logic              fis_valid,
  input  logic              fis_ready,
  output logic [7:0]        fis_addr,
  output logic [7:0]        fis_data,
  output logic [2:0]        port_is,
  output logic [SLOTS-1:0]  cmd_issue,
  output logic [SLOTS-1:0]  active,
  output logic [NPORTS-1:0] hba_is,
  output logic              irq
);
  fis_kind_e         kind_q;
  logic [SLOT_W-1:0] slot_q;
  logic [15:0]       tfd_q;
  logic              pkt_q;
  logic              wrote_q;
  logic              fin;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;

  statfis_byte_tx #(.SLOT_W(SLOT_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid),
    .req_ready_o(req_ready),
    .req_kind_i (fis_kind_e'(req_kind)),
    .req_slot_i (req_slot),
    .req_tfd_i  (req_tfd),
    .fis_en_i   (fis_en),
    .pkt_i      (pkt_dev),
    .out_ready_i(fis_ready),
    .last_idx_i (last_idx),
    .out_valid_o(fis_valid),
    .idx_o      (idx),
    .kind_o     (kind_q),
    .slot_o     (slot_q),
    .tfd_o      (tfd_q),
    .pkt_o      (pkt_q),
    .wrote_o    (wrote_q),
    .fin_o      (fin)
  );

  statfis_frame_gen #(.SLOT_W(SLOT_W)) u_gen (
    .kind_i    (kind_q),
    .slot_i    (slot_q),
    .tfd_i     (tfd_q),
    .pkt_i     (pkt_q),
    .idx_i     (idx),
    .last_idx_o(last_idx),
    .addr_o    (fis_addr),
    .data_o    (fis_data)
  );

  statfis_status #(.SLOTS(SLOTS), .NPORTS(NPORTS), .PORT_IDX(PORT_IDX)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_i    (fin),
    .kind_i   (kind_q),
    .slot_i   (slot_q),
    .err_bit_i(tfd_q[0]),
    .wrote_i  (wrote_q),
    .is_clr_i (port_is_clr),
    .ci_set_i (ci_set),
    .act_set_i(act_set),
    .glb_ie_i (glb_ie),
    .port_is_o(port_is),
    .ci_o     (cmd_issue),
    .act_o    (active),
    .hba_is_o (hba_is),
    .irq_o    (irq)
  );

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid && !fis_ready |=> fis_valid && $stable(fis_addr) && $stable(fis_data));

  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid |-> ((fis_addr >= 8'h40 && fis_addr <= 8'h53) ||
                   (fis_addr >= 8'h58 && fis_addr <= 8'h5F)));

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid |-> !req_ready);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glb_ie && (|port_is));
endmodule

// File: tb/statfis_top_test.sv
module statfis_top_test;
  localparam int SLOTS = 32;
  localparam int NP    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_kind = 2'd0;
  logic [4:0]       req_slot = 5'd0;
  logic [15:0]      req_tfd = 16'h0;
  logic             fis_en = 1'b1;
  logic             pkt_dev = 1'b0;
  logic             glb_ie = 1'b0;
  logic [2:0]       port_is_clr = 3'b0;
  logic [SLOTS-1:0] ci_set = '0;
  logic [SLOTS-1:0] act_set = '0;
  logic             fis_valid;
  logic             fis_ready = 1'b0;
  logic [7:0]       fis_addr;
  logic [7:0]       fis_data;
  logic [2:0]       port_is;
  logic [SLOTS-1:0] cmd_issue;
  logic [SLOTS-1:0] active;
  logic [NP-1:0]    hba_is;
  logic             irq;

  int nchk = 0;
  int nbad = 0;
  int rcnt = 0;
  logic [15:0] sb_q[$];

  always #5 clk = ~clk;

  statfis_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_slot(req_slot), .req_tfd(req_tfd),
    .fis_en(fis_en), .pkt_dev(pkt_dev), .glb_ie(glb_ie),
    .port_is_clr(port_is_clr), .ci_set(ci_set), .act_set(act_set),
    .fis_valid(fis_valid), .fis_ready(fis_ready), .fis_addr(fis_addr),
    .fis_data(fis_data), .port_is(port_is), .cmd_issue(cmd_issue),
    .active(active), .hba_is(hba_is), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // irregular back-pressure on the frame memory
  always @(posedge clk) begin
    #2;
    rcnt++;
    fis_ready <= ((rcnt % 5) != 2) && ((rcnt % 7) != 4);
  end

  // monitor: pops expected bytes as handshakes occur (R2..R5)
  always @(negedge clk) begin
    if (rst_n && fis_valid && fis_ready) begin
      if (sb_q.size() == 0) begin
        chk("R6 unexpected byte", {fis_addr, fis_data}, 16'hFFFF);
      end else begin
        logic [15:0] e;
        e = sb_q.pop_front();
        chk("R2-R5 frame byte", {fis_addr, fis_data}, e);
      end
    end
  end

  task automatic push_frame(input logic [1:0] k, input logic [4:0] s,
                            input logic [15:0] t, input logic pk);
    logic [31:0] m;
    logic [31:0] sg;
    m  = 32'd1 << s;
    sg = pk ? 32'hEB14_0101 : 32'h0000_0101;
    if (k == 2'd1) begin
      logic [7:0] b [8];
      b[0] = 8'hA1; b[1] = 8'h40; b[2] = t[7:0]; b[3] = t[15:8];
      b[4] = m[7:0]; b[5] = m[15:8]; b[6] = m[23:16]; b[7] = m[31:24];
      for (int i = 0; i < 8; i++) sb_q.push_back({8'h58 + 8'(i), b[i]});
    end else begin
      for (int i = 0; i < 20; i++) begin
        logic [7:0] d;
        d = 8'h00;
        if (i == 0) d = 8'h34;
        if (i == 1) d = 8'h40;
        if (i == 2) d = t[7:0];
        if (i == 3) d = t[15:8];
        if (k == 2'd2) begin
          if (i == 4)  d = sg[15:8];
          if (i == 5)  d = sg[23:16];
          if (i == 6)  d = sg[31:24];
          if (i == 12) d = sg[7:0];
        end
        sb_q.push_back({8'h40 + 8'(i), d});
      end
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [4:0] s,
                      input logic [15:0] t, input logic en, input logic pk);
    @(negedge clk);
    req_kind = k; req_slot = s; req_tfd = t; fis_en = en; pkt_dev = pk;
    if (en) push_frame(k, s, t, pk);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", req_ready, 1'b0);
    while (!req_ready) @(negedge clk);
    chk("R2/R6 all bytes seen", sb_q.size(), 0);
  endtask

  task automatic clr_is(input logic [2:0] v);
    @(negedge clk); port_is_clr = v;
    @(negedge clk); port_is_clr = 3'b0;
  endtask

  initial begin
    #100000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1'b1);
    chk("R2 reset valid", fis_valid, 1'b0);
    chk("R7 reset is", port_is, 3'b000);
    chk("R8 reset ci", cmd_issue, 0);
    chk("R8 reset act", active, 0);
    chk("R10 reset irq", irq, 1'b0);

    glb_ie = 1'b1;
    ci_set = (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 7) | (32'd1 << 31);
    act_set = 32'd1 << 7;
    @(negedge clk); ci_set = '0; act_set = '0;
    chk("R9 ci set", cmd_issue, 32'h8000_00A8);
    chk("R9 act set", active, 32'h0000_0080);

    send(2'd0, 5'd5, 16'h0050, 1'b1, 1'b0);
    chk("R8 ci slot5 cleared", cmd_issue, 32'h8000_0088);
    chk("R7 reg frame flag", port_is, 3'b001);
    chk("R10 hba_is", hba_is, 4'b0010);
    chk("R10 irq on", irq, 1'b1);

    clr_is(3'b001);
    chk("R7 w1c", port_is, 3'b000);
    chk("R10 irq off", irq, 1'b0);

    send(2'd1, 5'd7, 16'h0040, 1'b1, 1'b0);
    chk("R8 act slot7 cleared", active, 0);
    chk("R8 ci untouched by queued", cmd_issue, 32'h8000_0088);
    chk("R7 sdb flag", port_is, 3'b010);
    clr_is(3'b111);

    send(2'd0, 5'd31, 16'h0451, 1'b1, 1'b0);
    chk("R7 error flag", port_is, 3'b101);
    chk("R8 ci slot31 cleared", cmd_issue, 32'h0000_0088);

    @(negedge clk); glb_ie = 1'b0;
    @(negedge clk);
    chk("R10 irq gated", irq, 1'b0);
    chk("R10 hba_is kept", hba_is, 4'b0010);
    glb_ie = 1'b1;
    clr_is(3'b111);

    send(2'd0, 5'd3, 16'h0401, 1'b0, 1'b0);
    chk("R6 no frame flag, error kept", port_is, 3'b100);
    chk("R6 ci slot3 cleared", cmd_issue, 32'h0000_0080);
    clr_is(3'b111);

    send(2'd2, 5'd0, 16'h0050, 1'b1, 1'b0);
    chk("R5 reset flag", port_is, 3'b001);
    chk("R8 reset keeps ci", cmd_issue, 32'h0000_0080);
    send(2'd2, 5'd9, 16'h0050, 1'b1, 1'b1);
    clr_is(3'b111);

    send(2'd1, 5'd0, 16'h0241, 1'b1, 1'b0);
    chk("R4 sdb with error", port_is, 3'b110);
    send(2'd1, 5'd31, 16'h0040, 1'b1, 1'b0);
    clr_is(3'b111);

    send(2'd3, 5'd7, 16'h0050, 1'b1, 1'b0);
    chk("R3 kind3 clears ci", cmd_issue, 0);
    chk("R3 kind3 flag", port_is, 3'b001);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule